// File: doc/BRIEF.md
# Oversampled SPI Master

This block is an SPI master whose timing is counted entirely in system clock cycles. Every SPI bit period is stretched over a programmable number of system cycles. Inside each period the serial clock first holds its idle level and then its active level. The receive line is sampled on exactly one chosen sub-cycle of the period. The idle clock level, the active level of the slave select, the bit order and a lead-in delay between slave-select assertion and the first clock period are all set per transfer.

A client raises `xfer_req` while `ready` is high, together with a length in bits, a parallel transmit word and the configuration. The block captures all of these on the accepting edge, runs the transfer on `sclk`/`mosi`/`ss` while collecting `miso`, and returns `ready` high once slave select is released. The received bits appear right-aligned in `rx_word`. A second request, `tick_req`, produces a single clock period with no data and leaves slave select and the data line alone. This is useful for devices that need extra clocks.

Top module: `spi_os_master`

## Requirements
- R1: A bit period lasts M system cycles, where M is `clk_div`, and a `clk_div` of 0 is used as 1.
- R2: Within each bit period `sclk` holds the idle level for floor(M/2) cycles and the active level for the rest. The idle level is 0 when `cpol_high` is 0 and 1 when it is 1, and the active level is the inverse.
- R3: `mosi` carries one transmit bit for a whole bit period, starting at its first cycle. With `lsb_first`=0 the bits go out from `tx_word[L-1]` down to `tx_word[0]`. With `lsb_first`=1 they go out from `tx_word[0]` up to `tx_word[L-1]`.
- R4: `miso` is taken only on sub-cycle S of each period, counting from 0, where S is `samp_sel` clamped to M-1. Its value on every other sub-cycle has no effect on `rx_word`.
- R5: The bit received during the period that sent `tx_word[i]` is stored at `rx_word[i]`. Bits of `rx_word` at and above L are 0 once a transfer is done.
- R6: `ss` is at its active level (`ss_high`) from the cycle after acceptance. There are `lead_dly` cycles with `sclk` idle and `mosi` 0 before the first period begins.
- R7: In the cycle after the last bit period, `sclk` is idle, `mosi` is 0, `ss` is inactive and `ready` is 1.
- R8: `ready` is 0 from the cycle after an accepted request until the end of the operation. All configuration, length and transmit inputs are captured on the accepting edge, and later changes to them have no effect on the operation in progress.
- R9: An accepted `tick_req` gives one period of M cycles with the idle then active clock pattern of R2. During it, `ss` stays inactive, `mosi` stays 0 and `ready` is 0.
- R10: A synchronous active-high `rst` sets `sclk` to the level of `cpol_high`, sets `ss` to the inverse of `ss_high`, clears `mosi` and raises `ready`.
- R11: The length L is `xfer_len`, with 0 used as 1 and values above WIDTH used as WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_req | input | 1 | Start a data transfer (taken when ready is high) |
| tick_req | input | 1 | Issue one clock period without data (xfer_req wins) |
| ready | output | 1 | Block is idle and accepts a request |
| xfer_len | input | LEN_W | Transfer length in bits |
| tx_word | input | WIDTH | Parallel transmit data, right-aligned |
| rx_word | output | WIDTH | Parallel receive data, right-aligned |
| clk_div | input | DIV_W | System cycles per bit period |
| samp_sel | input | DIV_W | Sub-cycle on which miso is taken |
| cpol_high | input | 1 | 1: serial clock idles high; 0: idles low |
| ss_high | input | 1 | Active level of slave select |
| lsb_first | input | 1 | 1: bit 0 first; 0: highest bit first |
| lead_dly | input | DLY_W | Cycles between slave-select assertion and first period |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| ss | output | 1 | Slave select |

## Verification
The assertions assume that `miso` is a clean synchronous level in each system cycle. They also assume that `xfer_req` and `tick_req` matter only while `ready` is high, because they are ignored at other times. The stimulus drives `miso` on the falling clock edge. It sets the line to the expected bit on the chosen sample sub-cycle and to the inverse on every other sub-cycle, so a sample taken at the wrong point shows up as a wrong `rx_word`. Right after each request is accepted, the bench changes the configuration, length and data inputs to unrelated values. This checks that the block relies only on what it captured.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TICK
    } spi_state_e;

    typedef struct packed {
        logic idle_lvl;
        logic ss_lvl;
        logic lsb_first;
    } spi_fmt_t;

    function automatic int fold_mult(input int d);
        return (d < 1) ? 1 : d;
    endfunction

    function automatic int fold_samp(input int s, input int m);
        return (s > m - 1) ? m - 1 : s;
    endfunction

    function automatic int fold_len(input int l, input int w);
        if (l < 1) return 1;
        if (l > w) return w;
        return l;
    endfunction

endpackage

// File: rtl/spi_os_timer.sv
module spi_os_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] mult,
    input  logic [DIV_W-1:0] samp,
    output logic             phase_act,
    output logic             samp_hit,
    output logic             period_end
);
    logic [DIV_W-1:0] sub_q;
    logic [DIV_W-1:0] half;

    assign half       = mult >> 1;
    assign phase_act  = (sub_q >= half);
    assign samp_hit   = run && (sub_q == samp);
    assign period_end = run && (sub_q == mult - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run)      sub_q <= '0;
        else if (period_end)  sub_q <= '0;
        else                  sub_q <= sub_q + DIV_W'(1);
    end

    // R1
    sub_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (sub_q < mult));

endmodule

// File: rtl/spi_os_lane.sv
module spi_os_lane #(
    parameter int WIDTH = 16,
    parameter int LEN_W = 5,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             lsb_in,
    input  logic [LEN_W-1:0] len_in,
    input  logic [WIDTH-1:0] tx_in,
    input  logic             step,
    input  logic             cap,
    input  logic             miso,
    output logic             tx_bit,
    output logic             last,
    output logic [WIDTH-1:0] rx_word
);
    logic [WIDTH-1:0] tx_q;
    logic [WIDTH-1:0] rx_q;
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] len_q;
    logic             lsb_q;

    assign tx_bit  = tx_q[idx_q];
    assign last    = lsb_q ? (LEN_W'(idx_q) == len_q - LEN_W'(1)) : (idx_q == '0);
    assign rx_word = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            rx_q  <= '0;
            idx_q <= '0;
            len_q <= LEN_W'(1);
            lsb_q <= 1'b0;
        end else if (load) begin
            tx_q  <= tx_in;
            rx_q  <= '0;
            len_q <= len_in;
            lsb_q <= lsb_in;
            idx_q <= lsb_in ? '0 : IDX_W'(len_in - LEN_W'(1));
        end else begin
            if (cap)  rx_q[idx_q] <= miso;
            if (step) idx_q <= lsb_q ? idx_q + IDX_W'(1) : idx_q - IDX_W'(1);
        end
    end

    // R5
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        LEN_W'(idx_q) < len_q);

    // R5
    rx_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_q >> len_q) == '0);

endmodule

// File: rtl/spi_os_master.sv
module spi_os_master
    import spi_os_pkg::*;
#(
    parameter  int WIDTH = 16,
    parameter  int DIV_W = 8,
    parameter  int DLY_W = 8,
    localparam int LEN_W = $clog2(WIDTH + 1),
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer_req,
    input  logic             tick_req,
    output logic             ready,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [WIDTH-1:0] tx_word,
    output logic [WIDTH-1:0] rx_word,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [DIV_W-1:0] samp_sel,
    input  logic             cpol_high,
    input  logic             ss_high,
    input  logic             lsb_first,
    input  logic [DLY_W-1:0] lead_dly,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             ss
);
    spi_state_e       state_q;
    spi_fmt_t         fmt_q;
    logic [DIV_W-1:0] mult_q, samp_q;
    logic [DLY_W-1:0] dly_q, dcnt_q;

    logic             run, phase_act, samp_hit, period_end;
    logic             tx_bit, lane_last, lane_load;
    logic [DIV_W-1:0] mult_in, samp_in;
    logic [LEN_W-1:0] len_in;

    assign mult_in = DIV_W'(fold_mult(int'(clk_div)));
    assign samp_in = DIV_W'(fold_samp(int'(samp_sel), int'(mult_in)));
    assign len_in  = LEN_W'(fold_len(int'(xfer_len), WIDTH));

    assign run       = (state_q == ST_SHIFT) || (state_q == ST_TICK);
    assign lane_load = (state_q == ST_IDLE) && xfer_req;

    assign ready = (state_q == ST_IDLE);
    assign sclk  = (run && phase_act) ? ~fmt_q.idle_lvl : fmt_q.idle_lvl;
    assign mosi  = (state_q == ST_SHIFT) && tx_bit;
    assign ss    = ((state_q == ST_LEAD) || (state_q == ST_SHIFT)) ? fmt_q.ss_lvl : ~fmt_q.ss_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            fmt_q   <= '{idle_lvl: cpol_high, ss_lvl: ss_high, lsb_first: 1'b0};
            mult_q  <= DIV_W'(1);
            samp_q  <= '0;
            dly_q   <= '0;
            dcnt_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (xfer_req) begin
                        fmt_q   <= '{idle_lvl: cpol_high, ss_lvl: ss_high, lsb_first: lsb_first};
                        mult_q  <= mult_in;
                        samp_q  <= samp_in;
                        dly_q   <= lead_dly;
                        dcnt_q  <= '0;
                        state_q <= (lead_dly == '0) ? ST_SHIFT : ST_LEAD;
                    end else if (tick_req) begin
                        fmt_q.idle_lvl <= cpol_high;
                        mult_q  <= mult_in;
                        samp_q  <= samp_in;
                        state_q <= ST_TICK;
                    end
                end
                ST_LEAD: begin
                    dcnt_q <= dcnt_q + DLY_W'(1);
                    if (dcnt_q == dly_q - DLY_W'(1)) state_q <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (period_end && lane_last) state_q <= ST_IDLE;
                end
                ST_TICK: begin
                    if (period_end) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    spi_os_timer #(.DIV_W(DIV_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .mult       (mult_q),
        .samp       (samp_q),
        .phase_act  (phase_act),
        .samp_hit   (samp_hit),
        .period_end (period_end)
    );

    spi_os_lane #(.WIDTH(WIDTH), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_lane (
        .clk     (clk),
        .rst     (rst),
        .load    (lane_load),
        .lsb_in  (lsb_first),
        .len_in  (len_in),
        .tx_in   (tx_word),
        .step    ((state_q == ST_SHIFT) && period_end && !lane_last),
        .cap     ((state_q == ST_SHIFT) && samp_hit),
        .miso    (miso),
        .tx_bit  (tx_bit),
        .last    (lane_last),
        .rx_word (rx_word)
    );

    // R8
    ready_ss_chk: assert property (@(posedge clk) disable iff (rst)
        (ss == fmt_q.ss_lvl) |-> !ready);

    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (!mosi && (sclk == fmt_q.idle_lvl)));

    // R6
    lead_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LEAD) |-> (!mosi && (sclk == fmt_q.idle_lvl)));

    // R9
    tick_ss_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TICK) |-> ((ss != fmt_q.ss_lvl) && !mosi));

    // R2
    period_start_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(run) && (mult_q > DIV_W'(1))) |-> (sclk == fmt_q.idle_lvl));

endmodule

// File: tb/spi_os_master_tb.sv
module spi_os_master_tb;
    localparam int WIDTH = 16;
    localparam int LEN_W = $clog2(WIDTH + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic             xfer_req, tick_req, ready;
    logic [LEN_W-1:0] xfer_len;
    logic [WIDTH-1:0] tx_word, rx_word;
    logic [7:0]       clk_div, samp_sel, lead_dly;
    logic             cpol_high, ss_high, lsb_first;
    logic             sclk, mosi, miso, ss;

    int n_cmp = 0;
    int n_bad = 0;
    bit cur_sspol;

    always #4 clk = ~clk;

    spi_os_master u_dut (
        .clk(clk), .rst(rst), .xfer_req(xfer_req), .tick_req(tick_req), .ready(ready),
        .xfer_len(xfer_len), .tx_word(tx_word), .rx_word(rx_word),
        .clk_div(clk_div), .samp_sel(samp_sel), .cpol_high(cpol_high), .ss_high(ss_high),
        .lsb_first(lsb_first), .lead_dly(lead_dly), .sclk(sclk), .mosi(mosi),
        .miso(miso), .ss(ss)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic scramble();
        xfer_len  = 5'd3;
        tx_word   = 16'h5A5A;
        clk_div   = 8'd7;
        samp_sel  = 8'd0;
        lead_dly  = 8'd9;
        cpol_high = ~cpol_high;
        ss_high   = ~ss_high;
        lsb_first = ~lsb_first;
    endtask

    task automatic run_xfer(input int len, input logic [15:0] tx, input logic [15:0] rxp,
                            input int div, input int samp, input bit cpol, input bit sspol,
                            input bit lsb, input int dly);
        int m, s, l, total, u, k, c, idx;
        logic [15:0] exp_rx;
        m = (div < 1) ? 1 : div;
        s = (samp > m - 1) ? m - 1 : samp;
        l = (len < 1) ? 1 : ((len > WIDTH) ? WIDTH : len);
        total = dly + l * m;
        exp_rx = rxp & ((l == 16) ? 16'hFFFF : ((16'h1 << l) - 16'h1));
        @(negedge clk);
        xfer_len = LEN_W'(len); tx_word = tx; clk_div = 8'(div); samp_sel = 8'(samp);
        cpol_high = cpol; ss_high = sspol; lsb_first = lsb; lead_dly = 8'(dly);
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        scramble();                       // R8: later input changes must not matter
        cur_sspol = sspol;
        for (int t = 0; t < total; t++) begin
            chk("R8", "ready during transfer", {31'd0, ready}, 32'd0);
            chk("R6", "ss active", {31'd0, ss}, {31'd0, sspol});
            if (t < dly) begin
                chk("R6", "sclk in lead", {31'd0, sclk}, {31'd0, cpol});
                chk("R6", "mosi in lead", {31'd0, mosi}, 32'd0);
                miso = 1'b0;
            end else begin
                u = t - dly; k = u / m; c = u % m;
                idx = lsb ? k : l - 1 - k;
                chk("R1 R2", "sclk phase", {31'd0, sclk}, {31'd0, (c >= m / 2) ? ~cpol : cpol});
                chk("R3", "mosi bit", {31'd0, mosi}, {31'd0, tx[idx]});
                miso = (c == s) ? rxp[idx] : ~rxp[idx];   // R4
            end
            @(negedge clk);
        end
        chk("R7", "ready after", {31'd0, ready}, 32'd1);
        chk("R7", "ss after", {31'd0, ss}, {31'd0, ~sspol});
        chk("R7", "mosi after", {31'd0, mosi}, 32'd0);
        chk("R7", "sclk after", {31'd0, sclk}, {31'd0, cpol});
        chk("R4 R5 R11", "rx_word", {16'd0, rx_word}, {16'd0, exp_rx});
    endtask

    task automatic run_tick(input int div, input bit cpol);
        int m;
        m = (div < 1) ? 1 : div;
        @(negedge clk);
        clk_div = 8'(div); cpol_high = cpol; tick_req = 1'b1;
        @(negedge clk);
        tick_req = 1'b0; clk_div = 8'd13; cpol_high = ~cpol;
        for (int c = 0; c < m; c++) begin
            chk("R9", "sclk tick", {31'd0, sclk}, {31'd0, (c >= m / 2) ? ~cpol : cpol});
            chk("R9", "ss tick", {31'd0, ss}, {31'd0, ~cur_sspol});
            chk("R9", "mosi tick", {31'd0, mosi}, 32'd0);
            chk("R9", "ready tick", {31'd0, ready}, 32'd0);
            @(negedge clk);
        end
        chk("R9", "ready after tick", {31'd0, ready}, 32'd1);
        chk("R9", "sclk after tick", {31'd0, sclk}, {31'd0, cpol});
    endtask

    task automatic test_reset();
        rst = 1'b1; cpol_high = 1'b1; ss_high = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_sspol = 1'b1;
        chk("R10", "reset sclk", {31'd0, sclk}, 32'd1);
        chk("R10", "reset ss", {31'd0, ss}, 32'd0);
        chk("R10", "reset mosi", {31'd0, mosi}, 32'd0);
        chk("R10", "reset ready", {31'd0, ready}, 32'd1);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        xfer_req = 0; tick_req = 0; miso = 0; xfer_len = '0; tx_word = '0;
        clk_div = 8'd2; samp_sel = 8'd1; lead_dly = 8'd0; lsb_first = 0;
        cpol_high = 0; ss_high = 0;
        test_reset();
        run_xfer(8,  16'h00A5, 16'h003C, 4, 3, 1'b0, 1'b0, 1'b0, 0);
        run_xfer(12, 16'h0B3D, 16'h0A61, 5, 1, 1'b1, 1'b1, 1'b1, 3);
        run_xfer(16, 16'hC3E1, 16'h96F0, 1, 7, 1'b0, 1'b0, 1'b0, 2);
        run_xfer(5,  16'h0013, 16'h001A, 0, 0, 1'b1, 1'b0, 1'b1, 0);
        run_xfer(0,  16'h0001, 16'h0001, 3, 9, 1'b0, 1'b1, 1'b0, 1);
        run_xfer(20, 16'hFFFF, 16'h8001, 2, 0, 1'b1, 1'b1, 1'b0, 0);
        run_xfer(7,  16'h0055, 16'h0032, 6, 2, 1'b0, 1'b0, 1'b1, 5);
        run_tick(4, 1'b1);
        run_tick(3, 1'b0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule